// File: doc/BRIEF.md
# Seeded CCITT CRC16 Register Engine

This block is a small bus peripheral that computes a 16-bit CCITT CRC over a byte stream written by a processor. The processor reaches it through two byte-wide registers, a high byte and a low byte, on a simple synchronous bus. The bus has an address, a write enable, a read enable, 8-bit write data and 8-bit read data. The running remainder is a 16-bit state. The high register shows bits 15-8 of that state and the low register shows bits 7-0.

A calculation starts with a two-step seed. Software first writes the high register, which loads the upper seed byte and arms the seed. The next write to the low register then becomes the lower seed byte. Every later write to the low register is a data byte. The block folds that byte into the remainder, most significant bit first, using the polynomial 0x1021. It applies no reflection and no final XOR. The new remainder can be read on the next cycle, and the next byte can be written on that cycle too. Writing the high register again at any time starts a new seed.

Top module: `crc_seeded_engine`

## Requirements
- R1: After reset the CRC state is 0x0000 and no seed is armed, so the first low-register write after reset is treated as a data byte.
- R2: A write to the high register (address 1) loads the write data into state bits 15-8, leaves bits 7-0 unchanged and arms the seed.
- R3: While the seed is armed, a write to the low register (address 0) loads the write data into state bits 7-0, performs no CRC update, keeps bits 15-8 and disarms the seed.
- R4: While no seed is armed, a low-register write updates the state by shifting the 8 data bits in MSB first. For each bit, feedback = state[15] XOR data bit, the state shifts left by one, and it is XORed with 0x1021 when the feedback is 1. The result is readable on the cycle after the write.
- R5: Data bytes may be written on consecutive cycles, and each one is included in the remainder.
- R6: With read enable high, address 0 returns state bits 7-0 and address 1 returns bits 15-8, both combinationally from the current state. With read enable low, or at any other address, the read data is 0x00.
- R7: A high-register write restarts the seed sequence at any point, including in the middle of a stream and while a seed is already armed. The latest high byte is kept and the seed stays armed.
- R8: Writes to addresses other than 0 and 1 change neither the state nor the armed condition.
- R9: With seed 0xFFFF, the ASCII bytes "123456789" give 0x29B1. With seed 0x0000, the same bytes give 0x31C3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address: 0 low byte, 1 high byte |
| busWrEn | input | 1 | Write strobe for the current cycle |
| busRdEn | input | 1 | Read enable for the current cycle |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational |

## Verification
The assertions check on every cycle how the state moves for each kind of bus access. They cover the high-byte load and seed arming, the low seed load that disarms the seed, idle and ignored-address writes that leave everything stable, and zero read data when reads are off. Only the bench's scenarios show that a data byte produces the correct CCITT remainder. A behavioural reference model compares the read data on every cycle during back-to-back streams, re-seeds in mid-stream, an ignored-address write while the seed is armed, and the two standard check values.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  typedef struct packed {
    logic loadHigh;
    logic loadLow;
    logic feedByte;
  } crcStrobes_t;

  typedef enum logic {
    SEED_IDLE  = 1'b0,
    SEED_ARMED = 1'b1
  } seedState_t;
endpackage

// File: rtl/crc16_ctrl.sv
module crc16_ctrl
  import crc16_pkg::*;
#(
  parameter int AddrWidth = 2,
  parameter int LowAddr   = 0,
  parameter int HighAddr  = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [AddrWidth-1:0] busAddr,
  input  logic                 busWrEn,
  output crcStrobes_t          strobes,
  output logic                 seedPending
);
  localparam logic [AddrWidth-1:0] LowSel  = AddrWidth'(LowAddr);
  localparam logic [AddrWidth-1:0] HighSel = AddrWidth'(HighAddr);

  seedState_t seedState, seedNext;
  logic hitLow, hitHigh;

  always_comb begin
    hitLow  = busWrEn && (busAddr == LowSel);
    hitHigh = busWrEn && (busAddr == HighSel);
    strobes.loadHigh = hitHigh;
    strobes.loadLow  = hitLow && (seedState == SEED_ARMED);
    strobes.feedByte = hitLow && (seedState == SEED_IDLE);
  end

  always_comb begin
    seedNext = seedState;
    if (hitHigh)     seedNext = SEED_ARMED;
    else if (hitLow) seedNext = SEED_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) seedState <= SEED_IDLE;
    else       seedState <= seedNext;
  end

  assign seedPending = (seedState == SEED_ARMED);
endmodule

// File: rtl/crc16_datapath.sv
module crc16_datapath
  import crc16_pkg::*;
#(
  parameter int AddrWidth = 2,
  parameter int LowAddr   = 0,
  parameter int HighAddr  = 1,
  parameter int DataWidth = 8,
  parameter logic [2*DataWidth-1:0] Poly = 16'h1021
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  crcStrobes_t            strobes,
  input  logic [DataWidth-1:0]   busWrData,
  input  logic [AddrWidth-1:0]   busAddr,
  input  logic                   busRdEn,
  output logic [DataWidth-1:0]   busRdData,
  output logic [2*DataWidth-1:0] crcState
);
  localparam int CrcWidth = 2 * DataWidth;
  localparam int HiLsb    = CrcWidth - DataWidth;
  localparam logic [AddrWidth-1:0] LowSel  = AddrWidth'(LowAddr);
  localparam logic [AddrWidth-1:0] HighSel = AddrWidth'(HighAddr);

  // Unrolled bit-serial chain: stage 0 is the current state and each
  // later stage has consumed one more data bit, starting at the MSB.
  logic [CrcWidth-1:0] stageVal [DataWidth+1];
  assign stageVal[0] = crcState;

  for (genvar g = 0; g < DataWidth; g++) begin : g_bitStep
    logic fb;
    assign fb = stageVal[g][CrcWidth-1] ^ busWrData[DataWidth-1-g];
    assign stageVal[g+1] = {stageVal[g][CrcWidth-2:0], 1'b0} ^ (fb ? Poly : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcState <= '0;
    end else if (strobes.loadHigh) begin
      crcState[CrcWidth-1:HiLsb] <= busWrData;
    end else if (strobes.loadLow) begin
      crcState[DataWidth-1:0] <= busWrData;
    end else if (strobes.feedByte) begin
      crcState <= stageVal[DataWidth];
    end
  end

  always_comb begin
    busRdData = '0;
    if (busRdEn) begin
      if (busAddr == LowSel)       busRdData = crcState[DataWidth-1:0];
      else if (busAddr == HighSel) busRdData = crcState[CrcWidth-1:HiLsb];
    end
  end
endmodule

// File: rtl/crc_seeded_engine.sv
module crc_seeded_engine
  import crc16_pkg::*;
#(
  parameter int AddrWidth = 2,
  parameter int LowAddr   = 0,
  parameter int HighAddr  = 1,
  parameter int DataWidth = 8,
  parameter logic [2*DataWidth-1:0] Poly = 16'h1021
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [AddrWidth-1:0] busAddr,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [DataWidth-1:0] busWrData,
  output logic [DataWidth-1:0] busRdData
);
  localparam int CrcWidth = 2 * DataWidth;

  crcStrobes_t         strobes;
  logic                seedPending;
  logic [CrcWidth-1:0] crcState;

  crc16_ctrl #(
    .AddrWidth(AddrWidth), .LowAddr(LowAddr), .HighAddr(HighAddr)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .strobes(strobes), .seedPending(seedPending)
  );

  crc16_datapath #(
    .AddrWidth(AddrWidth), .LowAddr(LowAddr), .HighAddr(HighAddr),
    .DataWidth(DataWidth), .Poly(Poly)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWrData(busWrData),
    .busAddr(busAddr), .busRdEn(busRdEn), .busRdData(busRdData),
    .crcState(crcState)
  );
endmodule

// File: rtl/crc16_checker.sv
module crc16_checker #(
  parameter int AddrWidth = 2,
  parameter int LowAddr   = 0,
  parameter int HighAddr  = 1,
  parameter int DataWidth = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [AddrWidth-1:0]   busAddr,
  input logic                   busWrEn,
  input logic                   busRdEn,
  input logic [DataWidth-1:0]   busWrData,
  input logic [DataWidth-1:0]   busRdData,
  input logic [2*DataWidth-1:0] crcState,
  input logic                   seedPending
);
  localparam int CrcWidth = 2 * DataWidth;
  localparam int HiLsb    = CrcWidth - DataWidth;

  logic wrLow, wrHigh;
  assign wrLow  = busWrEn && (busAddr == AddrWidth'(LowAddr));
  assign wrHigh = busWrEn && (busAddr == AddrWidth'(HighAddr));

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (crcState == '0) && !seedPending);

  a_r2_high_load: assert property (@(posedge clk) disable iff (!rstN)
    wrHigh |=> (crcState[CrcWidth-1:HiLsb] == $past(busWrData)) &&
               (crcState[DataWidth-1:0] == $past(crcState[DataWidth-1:0])));

  a_r7_high_arms: assert property (@(posedge clk) disable iff (!rstN)
    wrHigh |=> seedPending);

  a_r3_seed_low: assert property (@(posedge clk) disable iff (!rstN)
    (wrLow && seedPending) |=>
      (crcState == {$past(crcState[CrcWidth-1:HiLsb]), $past(busWrData)}) && !seedPending);

  a_r4_data_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    (wrLow && !seedPending) |=> !seedPending);

  a_r8_quiet_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!wrLow && !wrHigh) |=> $stable(crcState) && $stable(seedPending));

  a_r6_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |-> (busRdData == '0));
endmodule

bind crc_seeded_engine crc16_checker #(
  .AddrWidth(AddrWidth), .LowAddr(LowAddr), .HighAddr(HighAddr), .DataWidth(DataWidth)
) u_checker (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busWrData(busWrData), .busRdData(busRdData), .crcState(crcState),
  .seedPending(seedPending)
);

// File: tb/crc_seeded_engine_bench.sv
`timescale 1ns/1ps
module crc_seeded_engine_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;

  int compared = 0;
  int mismatched = 0;
  int refState = 0;
  bit refPending = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  crc_seeded_engine u_crc_seeded_engine (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData)
  );

  function automatic int feedModel(int s, int b);
    int r = s;
    for (int i = 7; i >= 0; i--) begin
      int fb = ((r >> 15) & 1) ^ ((b >> i) & 1);
      r = (r << 1) & 16'hFFFF;
      if (fb != 0) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic int modelRead(bit rd, int addr);
    if (!rd) return 0;
    if (addr == 0) return refState & 8'hFF;
    if (addr == 1) return (refState >> 8) & 8'hFF;
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive at the falling edge, compare the combinational read
  // against the model's current state, then advance the model at the rising edge.
  task automatic busCycle(string tag, bit wr, bit rd, int addr, int data);
    @(negedge clk);
    busWrEn = wr; busRdEn = rd; busAddr = addr[1:0]; busWrData = data[7:0];
    #1;
    check(tag, int'(busRdData), modelRead(rd, addr));
    @(posedge clk);
    if (wr) begin
      if (addr == 1) begin
        refState = (refState & 8'hFF) | ((data & 8'hFF) << 8);
        refPending = 1;
      end else if (addr == 0) begin
        if (refPending) refState = (refState & 16'hFF00) | (data & 8'hFF);
        else            refState = feedModel(refState, data);
        refPending = 0;
      end
    end
  endtask

  task automatic readWord(string tag, int exp);
    int lo, hi;
    @(negedge clk);
    busWrEn = 0; busRdEn = 1; busAddr = 2'd0; #1; lo = int'(busRdData);
    busAddr = 2'd1; #1; hi = int'(busRdData);
    check(tag, (hi << 8) | lo, exp);
  endtask

  task automatic seed(string tag, int value);
    busCycle(tag, 1, 1, 1, (value >> 8) & 8'hFF);
    busCycle(tag, 1, 1, 0, value & 8'hFF);
  endtask

  task automatic feedString(string tag, string s);
    for (int i = 0; i < s.len(); i++) busCycle(tag, 1, 1, i % 2, 0) ;
  endtask

  task automatic feedBytes(string tag, string s);
    for (int i = 0; i < s.len(); i++) busCycle(tag, 1, 1, 0, int'(s[i]));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1: reset state and reads of both registers
    busCycle("R1", 0, 1, 0, 0);
    busCycle("R1", 0, 1, 1, 0);
    readWord("R1", 16'h0000);
    // R1/R4: first low write after reset is data, not seed
    busCycle("R1", 1, 0, 0, 8'h31);
    readWord("R4", feedModel(0, 8'h31));
    // R2: high write keeps low byte
    busCycle("R2", 1, 1, 1, 8'hFF);
    busCycle("R2", 0, 1, 0, 0);
    busCycle("R2", 0, 1, 1, 0);
    // R3: low seed byte, no update
    busCycle("R3", 1, 1, 0, 8'hFF);
    readWord("R3", 16'hFFFF);
    // R5: back-to-back stream, reading low byte every cycle
    feedBytes("R5", "123456789");
    readWord("R9", 16'h29B1);
    // R7: re-seed mid-stream, double high write
    seed("R7", 16'hFFFF);
    feedBytes("R7", "1234");
    busCycle("R7", 1, 1, 1, 8'h12);
    busCycle("R7", 1, 1, 1, 8'h34);
    // R8: ignored addresses while armed
    busCycle("R8", 1, 1, 2, 8'hAA);
    busCycle("R8", 1, 1, 3, 8'h55);
    readWord("R8", 16'h3400 | (feedModel(feedModel(feedModel(feedModel(16'hFFFF, 8'h31), 8'h32), 8'h33), 8'h34) & 8'hFF));
    busCycle("R7", 1, 1, 0, 8'h56);   // still armed: seed low
    readWord("R7", 16'h3456);
    feedBytes("R7", "AB");
    readWord("R7", feedModel(feedModel(16'h3456, 8'h41), 8'h42));
    // R9: zero seed
    seed("R9", 16'h0000);
    feedBytes("R9", "123456789");
    readWord("R9", 16'h31C3);
    // R6: read disabled returns zero, read of unmapped address returns zero
    busCycle("R6", 0, 0, 0, 0);
    busCycle("R6", 0, 0, 1, 0);
    busCycle("R6", 0, 1, 2, 0);
    // R4: single byte update checked against model
    busCycle("R4", 1, 1, 0, 8'hA5);
    readWord("R4", refState);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule